// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Clear-to-Send / Request-to-Send Flow Control

This block is one transmit channel of an asynchronous serial port. A character is written into a one-deep holding register. From there it is moved into a shift register and sent as a start bit, eight data bits with the least significant bit first, and one stop bit. A high line level is mark and a low level is space. The bit rate comes from one of three sources: an internal enable pulse at sixteen times the bit rate, an external clock at sixteen times the bit rate, or an external clock at the bit rate. An external clock is synchronized, and the bit timing advances on its falling edges.

Flow control works in two directions. An active-low clear-to-send input, when enabled, holds back the start of each new character. It never cuts a character that has already begun. An active-low request-to-send output is set and cleared by command pulses. It can also be released automatically once the last character has fully left the line.

The active-low ready output tells the writer when the holding register is free. The holding register empties as soon as a character starts, so a second character can wait in it while the first one is sent. This allows back-to-back frames with no idle gap between them.

Top module: `async_tx_flow`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `ser_out`, `rts_n` and `tx_ready_n` are all 1.
- R2: A frame is one low start bit, then `wr_data` bits 0 to 7 in that order, then one high stop bit. With `clk_sel` = 2'b00, each bit lasts exactly 16 cycles in which `tick16` is high.
- R3: With `clk_sel` = 2'b01, each bit lasts 16 falling edges of `ext_clk`. With `clk_sel` = 2'b10 or 2'b11, each bit lasts one falling edge. `ext_clk` passes through a two-stage synchronizer before its edges are detected.
- R4: While `tx_en` is 0, `ser_out` is 1 and `tx_ready_n` is 1, and writes are ignored. Dropping `tx_en` during a character aborts that character and empties the holding register.
- R5: While `loopback` is 1, characters are taken from the holding register and timed as usual, but `ser_out` stays 1.
- R6: When `cts_en` is 1, a start bit begins only while the synchronized `cts_n` is 0. A character that has already started always runs through its stop bit.
- R7: `tx_ready_n` is 0 exactly when `tx_en` is 1 and the holding register is empty. A write while the register is full is ignored. The register empties in the same cycle a start bit begins.
- R8: An `rts_set` pulse drives `rts_n` to 0 on the next cycle, and an `rts_clr` pulse drives it to 1. When both are high in the same cycle, `rts_set` wins.
- R9: With `auto_rts` at 1, `rts_n` goes to 1 on the cycle after the last enable of a stop bit, provided the holding register is empty and no write is accepted in that cycle. Otherwise `rts_n` is left as it is.
- R10: If the holding register is full when a stop bit ends, and the clear-to-send check of R6 allows it, the next start bit begins at once, with no idle bit time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enable |
| loopback | input | 1 | Local loopback: line held at mark |
| clk_sel | input | 2 | Bit clock source: 00 internal x16, 01 external x16, 1x external x1 |
| tick16 | input | 1 | Internal x16 enable pulse |
| ext_clk | input | 1 | External bit clock (asynchronous) |
| cts_en | input | 1 | Honour clear-to-send |
| cts_n | input | 1 | Active-low clear-to-send (asynchronous) |
| auto_rts | input | 1 | Release request-to-send after the final character |
| rts_set | input | 1 | Pulse: assert request-to-send |
| rts_clr | input | 1 | Pulse: release request-to-send |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Character to send |
| ser_out | output | 1 | Serial line, idle high |
| rts_n | output | 1 | Active-low request-to-send |
| tx_ready_n | output | 1 | Active-low: holding register can accept a character |

## Verification
Two things can happen in the same cycle: the automatic release of request-to-send at the last enable of a stop bit, and a new write into the empty holding register. To reach that cycle exactly, the bench turns off its free-running x16 enable and steps the enable by hand. It counts 161 enables from the load of a character, so it knows which cycle ends the stop bit, and places the write on that enable.

The release must be suppressed, and `rts_n` must stay low. After the written character goes out with no further write, `rts_n` must rise on the cycle after its stop bit ends and not one cycle earlier. The same hand-stepped run also checks the line value at the middle of each bit of the frame.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } tx_state_t;

  localparam logic [1:0] CK_INT16 = 2'b00;
  localparam logic [1:0] CK_EXT16 = 2'b01;
endpackage

// File: rtl/tx_sync.sv
module tx_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] r;

  always_ff @(posedge clk) begin
    if (rst) r <= {STAGES{RST_VAL}};
    else     r <= {r[STAGES-2:0], d};
  end

  assign q = r[STAGES-1];
endmodule

// File: rtl/tx_baud_sel.sv
module tx_baud_sel
  import async_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] clk_sel,
  input  logic       tick16,
  input  logic       ext_s,
  output logic       ena,
  output logic       one_x
);
  logic ext_prev;
  logic ext_fall;

  always_ff @(posedge clk) begin
    if (rst) ext_prev <= 1'b1;
    else     ext_prev <= ext_s;
  end

  assign ext_fall = ext_prev & ~ext_s;

  always_comb begin
    case (clk_sel)
      CK_INT16: begin ena = tick16;   one_x = 1'b0; end
      CK_EXT16: begin ena = ext_fall; one_x = 1'b0; end
      default:  begin ena = ext_fall; one_x = 1'b1; end
    endcase
  end
endmodule

// File: rtl/tx_serializer.sv
module tx_serializer
  import async_tx_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tx_en,
  input  logic          loopback,
  input  logic          ena,
  input  logic          one_x,
  input  logic          cts_ok,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  output logic          ser_out,
  output logic          tx_ready_n,
  output logic          load,
  output logic          drained
);
  localparam int SUB_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int BIT_W = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DW - 1);

  tx_state_t        st, st_nx;
  logic [SUB_W-1:0] sub, sub_nx;
  logic [BIT_W-1:0] bitn, bit_nx;
  logic [DW-1:0]    sh, sh_nx, hold, hold_nx;
  logic             full, full_nx;
  logic             wr_acc, last, can_start, ena_g;

  always_comb begin
    st_nx   = st;
    sub_nx  = sub;
    bit_nx  = bitn;
    sh_nx   = sh;
    hold_nx = hold;
    full_nx = full;
    load    = 1'b0;
    drained = 1'b0;
    ena_g     = ena & tx_en;
    wr_acc    = wr_valid & tx_en & ~full;
    last      = one_x | (sub == SUB_LAST);
    can_start = full & cts_ok;
    if (wr_acc) begin
      hold_nx = wr_data;
      full_nx = 1'b1;
    end
    if (ena_g) begin
      case (st)
        ST_IDLE: if (can_start) load = 1'b1;
        ST_START: begin
          if (last) begin
            st_nx  = ST_DATA;
            sub_nx = '0;
            bit_nx = '0;
          end else sub_nx = sub + SUB_W'(1);
        end
        ST_DATA: begin
          if (last) begin
            sh_nx  = sh >> 1;
            sub_nx = '0;
            if (bitn == BIT_LAST) st_nx = ST_STOP;
            else bit_nx = bitn + BIT_W'(1);
          end else sub_nx = sub + SUB_W'(1);
        end
        default: begin
          if (last) begin
            sub_nx = '0;
            if (can_start) load = 1'b1;
            else begin
              st_nx   = ST_IDLE;
              drained = ~full & ~wr_acc;
            end
          end else sub_nx = sub + SUB_W'(1);
        end
      endcase
    end
    if (load) begin
      sh_nx   = hold;
      full_nx = 1'b0;
      st_nx   = ST_START;
      sub_nx  = '0;
    end
    if (!tx_en) begin
      st_nx   = ST_IDLE;
      full_nx = 1'b0;
      sub_nx  = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      sub        <= '0;
      bitn       <= '0;
      sh         <= '1;
      hold       <= '0;
      full       <= 1'b0;
      ser_out    <= 1'b1;
      tx_ready_n <= 1'b1;
    end else begin
      st         <= st_nx;
      sub        <= sub_nx;
      bitn       <= bit_nx;
      sh         <= sh_nx;
      hold       <= hold_nx;
      full       <= full_nx;
      tx_ready_n <= ~(tx_en & ~full_nx);
      if (!tx_en || loopback)      ser_out <= 1'b1;
      else if (st_nx == ST_START)  ser_out <= 1'b0;
      else if (st_nx == ST_DATA)   ser_out <= sh_nx[0];
      else                         ser_out <= 1'b1;
    end
  end
endmodule

// File: rtl/async_tx_flow.sv
module async_tx_flow #(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              loopback,
  input  logic [1:0]        clk_sel,
  input  logic              tick16,
  input  logic              ext_clk,
  input  logic              cts_en,
  input  logic              cts_n,
  input  logic              auto_rts,
  input  logic              rts_set,
  input  logic              rts_clr,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              ser_out,
  output logic              rts_n,
  output logic              tx_ready_n
);
  logic cts_sync, ext_sync, ena, one_x, load, drained, cts_ok;

  tx_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst(rst), .d({cts_n, ext_clk}), .q({cts_sync, ext_sync})
  );

  tx_baud_sel u_baud (
    .clk(clk), .rst(rst), .clk_sel(clk_sel), .tick16(tick16),
    .ext_s(ext_sync), .ena(ena), .one_x(one_x)
  );

  assign cts_ok = ~cts_en | ~cts_sync;

  tx_serializer #(.DW(DATA_W), .OVS(OVS)) u_ser (
    .clk(clk), .rst(rst), .tx_en(tx_en), .loopback(loopback), .ena(ena),
    .one_x(one_x), .cts_ok(cts_ok), .wr_valid(wr_valid), .wr_data(wr_data),
    .ser_out(ser_out), .tx_ready_n(tx_ready_n), .load(load), .drained(drained)
  );

  always_ff @(posedge clk) begin
    if (rst)                              rts_n <= 1'b1;
    else if (rts_set)                     rts_n <= 1'b0;
    else if (rts_clr | (auto_rts & drained)) rts_n <= 1'b1;
  end
endmodule

// File: rtl/async_tx_flow_chk.sv
module async_tx_flow_chk (
  input logic clk,
  input logic rst,
  input logic tx_en,
  input logic loopback,
  input logic cts_en,
  input logic cts_sync,
  input logic load,
  input logic drained,
  input logic auto_rts,
  input logic rts_set,
  input logic rts_clr,
  input logic ser_out,
  input logic rts_n,
  input logic tx_ready_n
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (ser_out && rts_n && tx_ready_n));

  p_mark_when_off_r4: assert property (@(posedge clk) disable iff (rst)
    (!tx_en || loopback) |=> ser_out);

  p_not_ready_off_r4: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> tx_ready_n);

  p_cts_gate_r6: assert property (@(posedge clk) disable iff (rst)
    (load && cts_en) |-> !cts_sync);

  p_ready_after_load_r7: assert property (@(posedge clk) disable iff (rst)
    load |=> !tx_ready_n);

  p_rts_set_r8: assert property (@(posedge clk) disable iff (rst)
    rts_set |=> !rts_n);

  p_auto_release_r9: assert property (@(posedge clk) disable iff (rst)
    (auto_rts && drained && !rts_set) |=> rts_n);

  p_release_cause_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(rts_n) |-> ($past(rst) || $past(rts_clr) || $past(auto_rts && drained)));
endmodule

bind async_tx_flow async_tx_flow_chk u_chk (
  .clk(clk), .rst(rst), .tx_en(tx_en), .loopback(loopback), .cts_en(cts_en),
  .cts_sync(cts_sync), .load(load), .drained(drained), .auto_rts(auto_rts),
  .rts_set(rts_set), .rts_clr(rts_clr), .ser_out(ser_out), .rts_n(rts_n),
  .tx_ready_n(tx_ready_n)
);

// File: tb/async_tx_flow_bench.sv
module async_tx_flow_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, tx_en, loopback, tick16, ext_clk, cts_en, cts_n;
  logic auto_rts, rts_set, rts_clr, wr_valid;
  logic [1:0] clk_sel;
  logic [7:0] wr_data;
  logic ser_out, rts_n, tx_ready_n;

  logic auto_tick = 1'b1, tick_auto = 1'b0, man_tick = 1'b0;
  int   ext_half = 4, ext_cnt = 0;
  int   n_vec = 0, n_bad = 0;

  always @(negedge clk) tick_auto <= ~tick_auto;
  always @(negedge clk) ext_cnt <= (ext_cnt + 1 >= 2 * ext_half) ? 0 : ext_cnt + 1;
  assign tick16  = auto_tick ? tick_auto : man_tick;
  assign ext_clk = (ext_cnt < ext_half);

  async_tx_flow u_async_tx_flow (
    .clk(clk), .rst(rst), .tx_en(tx_en), .loopback(loopback), .clk_sel(clk_sel),
    .tick16(tick16), .ext_clk(ext_clk), .cts_en(cts_en), .cts_n(cts_n),
    .auto_rts(auto_rts), .rts_set(rts_set), .rts_clr(rts_clr),
    .wr_valid(wr_valid), .wr_data(wr_data), .ser_out(ser_out), .rts_n(rts_n),
    .tx_ready_n(tx_ready_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_valid = 1'b1; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic tk(input bit w, input logic [7:0] d);
    man_tick = 1'b1; wr_valid = w; wr_data = d;
    @(negedge clk);
    man_tick = 1'b0; wr_valid = 1'b0;
  endtask

  task automatic quiet(input int n, output int zeros);
    zeros = 0;
    repeat (n) begin
      @(negedge clk);
      if (ser_out == 1'b0) zeros++;
    end
  endtask

  task automatic wait_ready();
    int k = 0;
    while (tx_ready_n !== 1'b0 && k < 20000) begin @(negedge clk); k++; end
  endtask

  task automatic get_char(input int bitc, output logic [7:0] b, output int waited,
                          output bit ok);
    logic s0, s1;
    waited = 0; ok = 1'b0; b = '0;
    while (ser_out !== 1'b0 && waited < 20000) begin @(negedge clk); waited++; end
    if (waited >= 20000) return;
    repeat (bitc / 2) @(negedge clk);
    s0 = ser_out;
    for (int i = 0; i < 8; i++) begin
      repeat (bitc) @(negedge clk);
      b[i] = ser_out;
    end
    repeat (bitc) @(negedge clk);
    s1 = ser_out;
    ok = (s0 == 1'b0) && (s1 == 1'b1);
  endtask

  task automatic expect_char(input int bitc, input logic [7:0] exp, input string req,
                             input int max_wait);
    logic [7:0] b; int w; bit ok;
    get_char(bitc, b, w, ok);
    chk(req, {23'd0, ok, b}, {23'd0, 1'b1, exp});
    if (max_wait >= 0) chk({req, " R10 no idle gap"}, 32'(w <= max_wait), 32'd1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int z;
    rst = 1; tx_en = 0; loopback = 0; clk_sel = 2'b00; cts_en = 0; cts_n = 1;
    auto_rts = 0; rts_set = 0; rts_clr = 0; wr_valid = 0; wr_data = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ser_out", ser_out, 1); chk("R1 rts_n", rts_n, 1); chk("R1 tx_ready_n", tx_ready_n, 1);

    // R4 write while disabled is ignored
    wr(8'h55); repeat (5) @(negedge clk);
    chk("R4 ready while disabled", tx_ready_n, 1);
    tx_en = 1; repeat (3) @(negedge clk);
    chk("R7 ready after enable", tx_ready_n, 0);
    quiet(400, z); chk("R4 ignored write not sent", z, 0);

    // R2 full sweep of character values, back to back, internal x16
    fork
      for (int v = 0; v < 256; v++) begin wait_ready(); wr(8'(v)); end
      for (int v = 0; v < 256; v++) expect_char(32, 8'(v), "R2 sweep", -1);
    join

    // R5 loopback consumes characters, line stays mark
    repeat (50) @(negedge clk);
    loopback = 1; wr(8'h00); repeat (6) @(negedge clk);
    chk("R5 loopback char consumed", tx_ready_n, 0);
    quiet(400, z); chk("R5 loopback line mark", z, 0);
    loopback = 0; repeat (50) @(negedge clk);

    // R7 double buffering, write while full ignored, R10
    fork
      begin
        wr(8'hA1); repeat (6) @(negedge clk);
        chk("R7 ready reasserts after load", tx_ready_n, 0);
        wr(8'h5E); wr(8'hFF);
      end
      begin
        expect_char(32, 8'hA1, "R7 first", -1);
        expect_char(32, 8'h5E, "R7 second", 16);
      end
    join
    quiet(500, z); chk("R7 write while full dropped", z, 0);

    // R6 clear-to-send gating
    cts_en = 1; cts_n = 1; repeat (5) @(negedge clk);
    wr(8'h81); quiet(300, z);
    chk("R6 held off by CTS", z, 0); chk("R6 holding still full", tx_ready_n, 1);
    fork
      begin
        cts_n = 0;
        while (ser_out !== 1'b0) @(negedge clk);
        repeat (40) @(negedge clk);
        cts_n = 1; wr(8'h7E);
      end
      expect_char(32, 8'h81, "R6 in-flight completes", -1);
    join
    quiet(400, z); chk("R6 next start gated", z, 0);
    fork
      cts_n = 0;
      expect_char(32, 8'h7E, "R6 sent after CTS", -1);
    join
    cts_en = 0; repeat (50) @(negedge clk);

    // R4 abort on disable
    wr(8'h00);
    while (ser_out !== 1'b0) @(negedge clk);
    repeat (50) @(negedge clk);
    tx_en = 0; repeat (2) @(negedge clk);
    chk("R4 abort line mark", ser_out, 1); chk("R4 abort not ready", tx_ready_n, 1);
    tx_en = 1; quiet(400, z); chk("R4 aborted char not resumed", z, 0);

    // R3 external x1 clock, period 8 cycles
    clk_sel = 2'b10; ext_half = 4; repeat (20) @(negedge clk);
    fork
      begin wr(8'hC3); wait_ready(); wr(8'h3C); end
      begin
        expect_char(8, 8'hC3, "R3 ext x1 first", -1);
        expect_char(8, 8'h3C, "R3 ext x1 second", 4);
      end
    join
    repeat (50) @(negedge clk);

    // R3 external x16 clock, period 4 cycles
    clk_sel = 2'b01; ext_half = 2; repeat (20) @(negedge clk);
    fork
      begin wr(8'h96); wait_ready(); wr(8'h01); end
      begin
        expect_char(64, 8'h96, "R3 ext x16 first", -1);
        expect_char(64, 8'h01, "R3 ext x16 second", 32);
      end
    join
    repeat (100) @(negedge clk);

    // R8 / R9 with hand-stepped x16 enable
    clk_sel = 2'b00; auto_tick = 0; man_tick = 0; repeat (5) @(negedge clk);
    rts_set = 1; @(negedge clk); rts_set = 0; chk("R8 set", rts_n, 0);
    rts_clr = 1; @(negedge clk); rts_clr = 0; chk("R8 clear", rts_n, 1);
    rts_set = 1; rts_clr = 1; @(negedge clk); rts_set = 0; rts_clr = 0;
    chk("R8 set wins", rts_n, 0);
    auto_rts = 1;
    wr(8'hA5); chk("R7 no enable no load", tx_ready_n, 1);
    for (int t = 1; t <= 160; t++) begin
      tk(0, 8'h00);
      if (t == 9)   chk("R2 start bit", ser_out, 0);
      if (t >= 25 && t <= 137 && (t - 25) % 16 == 0)
        chk("R2 data bit", ser_out, 32'((8'hA5 >> ((t - 25) / 16)) & 1));
      if (t == 153) chk("R2 stop bit", ser_out, 1);
    end
    chk("R9 not released before stop end", rts_n, 0);
    tk(1, 8'h3C);
    chk("R9 write at stop end keeps rts", rts_n, 0);
    tk(0, 8'h00);
    chk("R7 ready after load", tx_ready_n, 0);
    for (int t = 163; t <= 321; t++) tk(0, 8'h00);
    chk("R9 one enable before end", rts_n, 0);
    tk(0, 8'h00);
    chk("R9 released after final stop", rts_n, 1);

    auto_rts = 0;
    rts_set = 1; @(negedge clk); rts_set = 0;
    wr(8'h0F);
    for (int t = 1; t <= 165; t++) tk(0, 8'h00);
    chk("R9 no release when off", rts_n, 0);
    auto_tick = 1;

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule